// File: doc/BRIEF.md
# Branch-Likely Resolve and Annul Unit

This unit sits in the decode stage of a five-stage pipeline with an architectural branch delay slot. It looks at the instruction in decode and works out whether it is a conditional branch. For a branch it evaluates the condition against the already-forwarded source operand values, computes the branch target, and produces a register-31 write request for the linking forms. Operand forwarding is handled outside this unit.

Ordinary branches always let their delay-slot instruction execute. The "likely" forms behave differently. When such a branch resolves not taken, the unit raises an annul request, and the pipeline loads a bubble into the fetch-to-decode latch in place of the delay-slot instruction. The annul is qualified by the advance of the branch out of decode, so a stalled branch never annuls.

The unit also keeps a one-bit flag that marks the instruction now in decode as a live delay-slot instruction. This flag is held across stalls.

Top module: `brl_resolve`

## Requirements
- R1: Opcodes 4 and 20 are taken when rs equals rt; opcodes 5 and 21 are taken when rs differs from rt. For all four, `uses_rt_o` is high. Opcodes 20 and 21 are the likely forms.
- R2: Opcodes 6 and 22 are taken when rs as a signed value is zero or negative. Opcodes 7 and 23 are taken when rs is strictly positive. The rt field is ignored, `uses_rt_o` is low, and 22 and 23 are the likely forms.
- R3: Opcode 1 decodes by the rt field. Codes 0, 2, 16 and 18 are taken when rs is negative. Codes 1, 3, 17 and 19 are taken when rs is zero or positive. Codes 2, 3, 18 and 19 are the likely forms.
- R4: For a recognised branch, `target_o` equals the instruction address plus 4 plus the sign-extended 16-bit offset shifted left by two.
- R5: Opcode 1 with rt codes 16 to 19 raises `link_we_o` with `link_addr_o` = 31 and `link_data_o` = address plus 8, whether or not the branch is taken. Every other instruction leaves all three at zero.
- R6: A valid likely branch that resolves not taken while `stall_i` is low raises `annul_o` in the same cycle.
- R7: A likely branch that is taken, and any non-likely branch, never raises `annul_o`.
- R8: While `stall_i` is high, `annul_o` stays low, whatever the branch outcome.
- R9: With `valid_i` low, or with an opcode or opcode-1 rt code outside the lists above, every output except `dslot_o` is zero.
- R10: `dslot_o` is low out of reset. It is high in the cycle after a valid branch advances (stall low) without annul. It holds its value while `stall_i` is high. Otherwise it is low after each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Decode holds a real instruction |
| stall_i | input | 1 | Decode stage held this cycle |
| opcode_i | input | 6 | Main opcode field |
| rt_sel_i | input | 5 | rt field (sub-code for opcode 1) |
| imm_i | input | 16 | Branch offset in words |
| pc_i | input | 32 | Address of the branch instruction |
| rs_val_i | input | 32 | Forwarded rs operand |
| rt_val_i | input | 32 | Forwarded rt operand |
| branch_o | output | 1 | Recognised conditional branch |
| taken_o | output | 1 | Branch condition true |
| target_o | output | 32 | Branch target address |
| uses_rt_o | output | 1 | Branch compares against rt |
| link_we_o | output | 1 | Write return address |
| link_addr_o | output | 5 | Link destination register |
| link_data_o | output | 32 | Return address |
| annul_o | output | 1 | Replace fetched delay-slot instruction with a bubble |
| dslot_o | output | 1 | Instruction in decode is a live delay slot |

## Verification
Most internal faults show up in the same cycle on the combinational outputs. A wrong decode of a likely bit or condition modifier flips `taken_o` or `annul_o` for the affected opcode. A faulty offset or link adder corrupts `target_o` or `link_data_o` immediately. The only state is the delay-slot flag. A fault there appears one clock after a branch advances, or after a stall releases, as a `dslot_o` value that disagrees with the branch's advance and annul history.

// File: rtl/brl_pkg.sv
package brl_pkg;

  localparam logic [5:0] OP_REGIMM = 6'd1;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_LTZ = 2'd1,
    CMP_LEZ = 2'd2
  } cmp_e;

  typedef struct packed {
    logic br;
    logic likely;
    logic link;
    logic inv;
    logic need_rt;
    cmp_e cmp;
  } br_ctrl_t;

endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [4:0] rt_sel_i,
  output br_ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    if (opcode_i == OP_REGIMM) begin
      // codes 0-3 and 16-19: bit0 invert, bit1 likely, bit4 link
      if (rt_sel_i[3:2] == 2'b00) begin
        ctrl_o.br     = 1'b1;
        ctrl_o.inv    = rt_sel_i[0];
        ctrl_o.likely = rt_sel_i[1];
        ctrl_o.link   = rt_sel_i[4];
        ctrl_o.cmp    = CMP_LTZ;
      end
    end else if (opcode_i[5] == 1'b0 && opcode_i[3:2] == 2'b01) begin
      // 4-7 ordinary, 20-23 likely; bit1 picks sign test over compare
      ctrl_o.br      = 1'b1;
      ctrl_o.inv     = opcode_i[0];
      ctrl_o.likely  = opcode_i[4];
      ctrl_o.need_rt = ~opcode_i[1];
      ctrl_o.cmp     = opcode_i[1] ? CMP_LEZ : CMP_EQ;
    end
  end

  always_comb begin
    a_link_regimm_r5: assert (!ctrl_o.link || opcode_i == OP_REGIMM);
  end

endmodule

// File: rtl/brl_cond.sv
module brl_cond
  import brl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_ctrl_t          ctrl_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rt_i,
  output logic              taken_o
);

  logic base;
  logic rs_neg;
  logic rs_zero;

  assign rs_neg  = rs_i[XLEN-1];
  assign rs_zero = (rs_i == '0);

  always_comb begin
    unique case (ctrl_i.cmp)
      CMP_EQ:  base = (rs_i == rt_i);
      CMP_LTZ: base = rs_neg;
      CMP_LEZ: base = rs_neg | rs_zero;
      default: base = 1'b0;
    endcase
  end

  assign taken_o = ctrl_i.br & (base ^ ctrl_i.inv);

endmodule

// File: rtl/brl_addr.sv
module brl_addr #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  link_o
);

  localparam int unsigned EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] offs;

  assign slot_pc  = pc_i + XLEN'(4);
  assign offs     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign target_o = slot_pc + offs;
  assign link_o   = pc_i + XLEN'(8);

endmodule

// File: rtl/brl_resolve.sv
module brl_resolve
  import brl_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned OP_W     = 6,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             stall_i,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [REG_W-1:0] rt_sel_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  output logic             branch_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  target_o,
  output logic             uses_rt_o,
  output logic             link_we_o,
  output logic [REG_W-1:0] link_addr_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic             annul_o,
  output logic             dslot_o
);

  br_ctrl_t        ctrl_raw;
  br_ctrl_t        ctrl;
  logic            cond_taken;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] lnk;
  logic            advance;
  logic            dslot_q;

  brl_decode u_dec (
    .opcode_i (opcode_i),
    .rt_sel_i (rt_sel_i),
    .ctrl_o   (ctrl_raw)
  );

  // invalid slots decode to nothing
  assign ctrl = valid_i ? ctrl_raw : '0;

  brl_cond #(.XLEN(XLEN)) u_cond (
    .ctrl_i  (ctrl),
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .taken_o (cond_taken)
  );

  brl_addr #(.XLEN(XLEN), .IMM_W(IMM_W)) u_addr (
    .pc_i     (pc_i),
    .imm_i    (imm_i),
    .target_o (tgt),
    .link_o   (lnk)
  );

  assign advance     = ~stall_i;
  assign branch_o    = ctrl.br;
  assign taken_o     = cond_taken;
  assign uses_rt_o   = ctrl.need_rt;
  assign target_o    = ctrl.br ? tgt : '0;
  assign link_we_o   = ctrl.link;
  assign link_addr_o = ctrl.link ? REG_W'(LINK_REG) : '0;
  assign link_data_o = ctrl.link ? lnk : '0;
  assign annul_o     = ctrl.likely & ~cond_taken & advance;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dslot_q <= 1'b0;
    else if (advance) dslot_q <= ctrl.br & ~annul_o;
  end

  assign dslot_o = dslot_q;

  p_annul_blocked_by_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !annul_o);

  p_annul_not_taken_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> (branch_o && !taken_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !branch_o |-> (!taken_o && !annul_o && !link_we_o && !uses_rt_o));

  p_dslot_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_o && !stall_i && !annul_o) |=> dslot_o);

  p_dslot_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(dslot_o));

  p_dslot_kill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |=> !dslot_o);

  p_link_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_addr_o == REG_W'(LINK_REG) && link_data_o == pc_i + XLEN'(8)));

endmodule

// File: tb/brl_resolve_test.sv
`timescale 1ns/1ps
module brl_resolve_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        stall_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [4:0]  rt_sel_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic        branch_o, taken_o, uses_rt_o, link_we_o, annul_o, dslot_o;
  logic [31:0] target_o, link_data_o;
  logic [4:0]  link_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_ds = 1'b0;

  always #5 clk_i = ~clk_i;

  brl_resolve uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .stall_i(stall_i),
    .opcode_i(opcode_i), .rt_sel_i(rt_sel_i), .imm_i(imm_i), .pc_i(pc_i),
    .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .branch_o(branch_o),
    .taken_o(taken_o), .target_o(target_o), .uses_rt_o(uses_rt_o),
    .link_we_o(link_we_o), .link_addr_o(link_addr_o),
    .link_data_o(link_data_o), .annul_o(annul_o), .dslot_o(dslot_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference model written from the requirement list
  task automatic apply(input string req, input logic v, input logic st,
                       input logic [5:0] op, input logic [4:0] rt,
                       input logic [15:0] imm, input logic [31:0] pc,
                       input logic [31:0] rs, input logic [31:0] rtv);
    logic isb, lik, lnk, urt, tk;
    logic [31:0] tgt;
    isb = 0; lik = 0; lnk = 0; urt = 0; tk = 0;
    if (v) begin
      case (op)
        6'd4:  begin isb = 1; urt = 1; tk = (rs == rtv); end
        6'd5:  begin isb = 1; urt = 1; tk = (rs != rtv); end
        6'd20: begin isb = 1; urt = 1; lik = 1; tk = (rs == rtv); end
        6'd21: begin isb = 1; urt = 1; lik = 1; tk = (rs != rtv); end
        6'd6:  begin isb = 1; tk = ($signed(rs) <= 0); end
        6'd7:  begin isb = 1; tk = ($signed(rs) > 0); end
        6'd22: begin isb = 1; lik = 1; tk = ($signed(rs) <= 0); end
        6'd23: begin isb = 1; lik = 1; tk = ($signed(rs) > 0); end
        6'd1: begin
          case (rt)
            5'd0:  begin isb = 1; tk = $signed(rs) < 0; end
            5'd1:  begin isb = 1; tk = $signed(rs) >= 0; end
            5'd2:  begin isb = 1; lik = 1; tk = $signed(rs) < 0; end
            5'd3:  begin isb = 1; lik = 1; tk = $signed(rs) >= 0; end
            5'd16: begin isb = 1; lnk = 1; tk = $signed(rs) < 0; end
            5'd17: begin isb = 1; lnk = 1; tk = $signed(rs) >= 0; end
            5'd18: begin isb = 1; lnk = 1; lik = 1; tk = $signed(rs) < 0; end
            5'd19: begin isb = 1; lnk = 1; lik = 1; tk = $signed(rs) >= 0; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    tgt = isb ? (pc + 32'd4 + ({{16{imm[15]}}, imm} * 32'd4)) : 32'd0;
    @(negedge clk_i);
    valid_i = v; stall_i = st; opcode_i = op; rt_sel_i = rt;
    imm_i = imm; pc_i = pc; rs_val_i = rs; rt_val_i = rtv;
    #1;
    chk(req, "branch", {31'd0, branch_o}, {31'd0, isb});
    chk(req, "taken", {31'd0, taken_o}, {31'd0, tk});
    chk(req, "target R4", target_o, tgt);
    chk(req, "uses_rt", {31'd0, uses_rt_o}, {31'd0, urt});
    chk(req, "link_we R5", {31'd0, link_we_o}, {31'd0, lnk});
    chk(req, "link_addr R5", {27'd0, link_addr_o}, lnk ? 32'd31 : 32'd0);
    chk(req, "link_data R5", link_data_o, lnk ? pc + 32'd8 : 32'd0);
    chk(req, "annul R6", {31'd0, annul_o}, {31'd0, lik & ~tk & ~st});
    if (!st) exp_ds = isb & ~(lik & ~tk);
    @(posedge clk_i); #1;
    chk(req, "dslot R10", {31'd0, dslot_o}, {31'd0, exp_ds});
  endtask

  task automatic t_reset;
    chk("R10", "dslot after reset", {31'd0, dslot_o}, 32'd0);
    chk("R9", "annul after reset", {31'd0, annul_o}, 32'd0);
  endtask

  task automatic t_equal_r1;
    apply("R1", 1, 0, 6'd4,  5'd3, 16'h0010, 32'h0000_1000, 32'd7, 32'd7);
    apply("R1", 1, 0, 6'd5,  5'd3, 16'hfff0, 32'h0000_2000, 32'd7, 32'd7);
    apply("R1", 1, 0, 6'd20, 5'd3, 16'h0004, 32'h0000_3000, 32'd5, 32'd9);
    apply("R1", 1, 0, 6'd21, 5'd3, 16'h0004, 32'h0000_3004, 32'd5, 32'd9);
    apply("R1", 1, 0, 6'd20, 5'd3, 16'h0004, 32'h0000_3008, 32'd9, 32'd9);
  endtask

  task automatic t_sign_r2;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] v;
      v = (k == 0) ? 32'd0 : (k == 1) ? 32'hffff_ffff : (k == 2) ? 32'd1 : 32'h8000_0000;
      apply("R2", 1, 0, 6'd6,  5'd9, 16'h0020, 32'h100, v, 32'd0);
      apply("R2", 1, 0, 6'd7,  5'd9, 16'h0020, 32'h100, v, 32'd0);
      apply("R2", 1, 0, 6'd22, 5'd9, 16'h8000, 32'h100, v, 32'd0);
      apply("R2", 1, 0, 6'd23, 5'd9, 16'h7fff, 32'h100, v, 32'd0);
    end
  endtask

  task automatic t_regimm_r3;
    logic [4:0] codes [8] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17, 5'd18, 5'd19};
    for (int i = 0; i < 8; i++) begin
      apply("R3", 1, 0, 6'd1, codes[i], 16'h0100, 32'h4000, 32'hffff_fffe, 32'd0);
      apply("R3", 1, 0, 6'd1, codes[i], 16'hff00, 32'h4000, 32'd0, 32'd0);
    end
  endtask

  task automatic t_link_r5;
    apply("R5", 1, 0, 6'd1, 5'd16, 16'h0001, 32'hfffffff8, 32'd3, 32'd0);
    apply("R5", 1, 0, 6'd1, 5'd19, 16'h0001, 32'h0000_5000, 32'h8000_0000, 32'd0);
  endtask

  task automatic t_stall_r8;
    apply("R10", 1, 0, 6'd4, 5'd0, 16'd1, 32'h600, 32'd1, 32'd1);
    apply("R8", 1, 1, 6'd20, 5'd0, 16'd1, 32'h600, 32'd1, 32'd2);
    apply("R8", 1, 1, 6'd1, 5'd2, 16'd1, 32'h600, 32'd5, 32'd0);
    apply("R6", 1, 0, 6'd1, 5'd2, 16'd1, 32'h600, 32'd5, 32'd0);
    apply("R10", 0, 1, 6'd0, 5'd0, 16'd0, 32'h0, 32'd0, 32'd0);
    apply("R7", 1, 0, 6'd1, 5'd3, 16'd2, 32'h700, 32'd5, 32'd0);
    apply("R10", 0, 0, 6'd4, 5'd0, 16'd0, 32'h0, 32'd0, 32'd0);
  endtask

  task automatic t_unsupported_r9;
    apply("R9", 1, 0, 6'd24, 5'd0, 16'd4, 32'h800, 32'd0, 32'd0);
    apply("R9", 1, 0, 6'd1,  5'd4, 16'd4, 32'h800, 32'hffff_ffff, 32'd0);
    apply("R9", 1, 0, 6'd1,  5'd20, 16'd4, 32'h800, 32'hffff_ffff, 32'd0);
    apply("R9", 1, 0, 6'd36, 5'd0, 16'd4, 32'h800, 32'd0, 32'd0);
    apply("R9", 0, 0, 6'd20, 5'd0, 16'd4, 32'h800, 32'd1, 32'd2);
  endtask

  initial begin
    fork
      begin
        #20 rst_ni = 1'b1;
        @(posedge clk_i); #1;
        t_reset();
        t_equal_r1();
        t_sign_r2();
        t_regimm_r3();
        t_link_r5();
        t_stall_r8();
        t_unsupported_r9();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule